// File: doc/BRIEF.md
# Internal State Readout Window

This block lets software inspect wide internal state records through a narrow 32-bit register port. A set of 448-bit records, one per hardware instance plus one for the software instance, arrives as a flat vector. Software writes a 4-bit selection register to pick one record. It then reads the value register repeatedly, and each read returns the next 32-bit slice of that record.

An internal word pointer counts the slices. It moves forward only on an accepted read of the value register. It wraps to zero after the last of the fourteen slices, and it returns to zero whenever the selection register is written. A selection that names no existing record reads as zero. The value register returns zero and the pointer holds unless two enables are both true: a control qualifier and a fuse-derived permission.

The register port has two word addresses. Address 0 is the selection register, which can be read and written. Address 1 is the value register, which is read-only. Read data is combinational during the cycle in which the read strobe is high.

Top module: `state_readout_window`

## Requirements
- R1: After reset the selection is 0 and the word pointer is 0, so the first value read returns bits 31:0 of record 0.
- R2: A write to address 0 stores bits 3:0 of the write data as the selection. A read of address 0 returns the selection in bits 3:0 and zero in bits 31:4.
- R3: Successive value reads (address 1) return the record's words in ascending order. Read k, counting from 0, returns record bits 32k+31 down to 32k.
- R4: After the 14th value read of a record, the pointer wraps, so the 15th read returns word 0 again.
- R5: Any write to address 0 resets the pointer to 0, including a write of the value already held.
- R6: A selection of NUM_HW+1 or higher reads as zero for every word, and the pointer still advances.
- R7: When the read qualifier or the fuse enable is low, a value read returns zero and leaves the pointer unchanged.
- R8: Reads of address 0 and reads of the unused addresses 2 and 3 never move the pointer. Unused addresses read as zero.
- R9: In every cycle without a read strobe, the read data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| records_i | input | (NUM_HW+1)*448 | Flat record vector, record r at bits r*448 upward |
| rd_qual_i | input | 1 | Internal-state read qualifier |
| fuse_en_i | input | 1 | Fuse-derived read permission |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid while reg_re_i is high |

## Verification
The bench loads each record with words computed from the record and word index, so any swapped, shifted or misaligned slice shows up as a wrong value. It sweeps all sixteen selections with fourteen reads each plus one wrap read, which separates valid records from reserved selections and confirms the pointer wraps. Interleaved patterns test the pointer's behaviour under other traffic. These include mid-record reselection, reads with either enable low, and reads of the selection register and unused addresses between value reads. Each pattern checks whether the pointer resets, holds or advances.

// File: rtl/srw_pkg.sv
package srw_pkg;

    localparam int DEF_WORD_W = 32;
    localparam int DEF_REC_W  = 448;
    localparam int DEF_SEL_W  = 4;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SEL  = 2'd0,
        ADDR_VAL  = 2'd1,
        ADDR_RSV2 = 2'd2,
        ADDR_RSV3 = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic wr_sel;
        logic rd_sel;
        logic rd_val;
    } access_t;

    function automatic access_t decode_access(logic we, logic re, logic [ADDR_W-1:0] addr);
        access_t a;
        a.wr_sel = we && (addr == ADDR_SEL);
        a.rd_sel = re && (addr == ADDR_SEL);
        a.rd_val = re && (addr == ADDR_VAL);
        return a;
    endfunction

endpackage

// File: rtl/srw_sel_reg.sv
module srw_sel_reg #(
    parameter int SEL_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  srw_pkg::access_t  acc_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [SEL_W-1:0]  sel_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_o <= '0;
        end else if (acc_i.wr_sel) begin
            sel_o <= wdata_i[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/srw_word_ptr.sv
module srw_word_ptr #(
    parameter int WORDS = 14,
    parameter int PTR_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  srw_pkg::access_t acc_i,
    input  logic             allow_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

    logic advance;
    assign advance = acc_i.rd_val && allow_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || acc_i.wr_sel) begin
            ptr_o <= '0;
        end else if (advance) begin
            ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/srw_rec_mux.sv
module srw_rec_mux #(
    parameter int NREC   = 3,
    parameter int REC_W  = 448,
    parameter int WORD_W = 32,
    parameter int SEL_W  = 4,
    parameter int PTR_W  = 4
) (
    input  logic [NREC*REC_W-1:0] records_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [PTR_W-1:0]      ptr_i,
    output logic [WORD_W-1:0]     word_o
);
    localparam int WORDS = REC_W / WORD_W;

    logic [WORD_W-1:0] words [NREC][WORDS];

    for (genvar r = 0; r < NREC; r++) begin : g_rec
        for (genvar k = 0; k < WORDS; k++) begin : g_word
            assign words[r][k] = records_i[r*REC_W + k*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        word_o = '0;
        for (int r = 0; r < NREC; r++) begin
            for (int k = 0; k < WORDS; k++) begin
                if (sel_i == SEL_W'(r) && ptr_i == PTR_W'(k)) begin
                    word_o = words[r][k];
                end
            end
        end
    end
endmodule

// File: rtl/state_readout_window.sv
module state_readout_window
    import srw_pkg::*;
#(
    parameter int NUM_HW = 2,
    parameter int REC_W  = DEF_REC_W,
    parameter int WORD_W = DEF_WORD_W,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [(NUM_HW+1)*REC_W-1:0] records_i,
    input  logic                        rd_qual_i,
    input  logic                        fuse_en_i,
    input  logic                        reg_we_i,
    input  logic                        reg_re_i,
    input  logic [ADDR_W-1:0]           reg_addr_i,
    input  logic [WORD_W-1:0]           reg_wdata_i,
    output logic [WORD_W-1:0]           reg_rdata_o
);
    localparam int NREC  = NUM_HW + 1;
    localparam int WORDS = REC_W / WORD_W;
    localparam int PTR_W = $clog2(WORDS);

    access_t           acc;
    logic [SEL_W-1:0]  sel_q;
    logic [PTR_W-1:0]  word_ptr;
    logic [WORD_W-1:0] rec_word;
    logic              rd_allow;

    assign acc      = decode_access(reg_we_i, reg_re_i, reg_addr_i);
    assign rd_allow = rd_qual_i && fuse_en_i;

    srw_sel_reg #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_sel (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .acc_i   (acc),
        .wdata_i (reg_wdata_i),
        .sel_o   (sel_q)
    );

    srw_word_ptr #(.WORDS(WORDS), .PTR_W(PTR_W)) u_ptr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .acc_i   (acc),
        .allow_i (rd_allow),
        .ptr_o   (word_ptr)
    );

    srw_rec_mux #(
        .NREC(NREC), .REC_W(REC_W), .WORD_W(WORD_W), .SEL_W(SEL_W), .PTR_W(PTR_W)
    ) u_mux (
        .records_i (records_i),
        .sel_i     (sel_q),
        .ptr_i     (word_ptr),
        .word_o    (rec_word)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (acc.rd_sel) begin
            reg_rdata_o = WORD_W'(sel_q);
        end else if (acc.rd_val && rd_allow) begin
            reg_rdata_o = rec_word;
        end
    end
endmodule

// File: rtl/srw_checker.sv
module srw_checker
    import srw_pkg::*;
#(
    parameter int NREC   = 3,
    parameter int WORDS  = 14,
    parameter int SEL_W  = 4,
    parameter int PTR_W  = 4,
    parameter int WORD_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input access_t           acc,
    input logic              re,
    input logic              allow,
    input logic [SEL_W-1:0]  sel,
    input logic [PTR_W-1:0]  ptr,
    input logic [WORD_W-1:0] rdata
);
    // R3: the pointer stays inside the record
    a_r3_ptr_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        ptr < PTR_W'(WORDS));

    // R4: wrap after the last word
    a_r4_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc.rd_val && allow && !acc.wr_sel && ptr == PTR_W'(WORDS-1)) |=> ptr == '0);

    // R5: selection write clears the pointer
    a_r5_sel_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        acc.wr_sel |=> ptr == '0);

    // R6: reserved selection reads zero
    a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc.rd_val && sel >= SEL_W'(NREC)) |-> rdata == '0);

    // R7: disabled reads hold the pointer and read zero
    a_r7_hold_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc.rd_val && !allow && !acc.wr_sel) |=> $stable(ptr));
    a_r7_zero_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc.rd_val && !allow) |-> rdata == '0);

    // R8: reads elsewhere do not move the pointer
    a_r8_other_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (re && !acc.rd_val && !acc.wr_sel) |=> $stable(ptr));

    // R9: idle read data is zero
    a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !re |-> rdata == '0);
endmodule

bind state_readout_window srw_checker #(
    .NREC(NREC), .WORDS(WORDS), .SEL_W(SEL_W), .PTR_W(PTR_W), .WORD_W(WORD_W)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .acc   (acc),
    .re    (reg_re_i),
    .allow (rd_allow),
    .sel   (sel_q),
    .ptr   (word_ptr),
    .rdata (reg_rdata_o)
);

// File: tb/state_readout_window_bench.sv
`timescale 1ns/1ps
module state_readout_window_bench;
    localparam int NUM_HW = 2;
    localparam int NREC   = NUM_HW + 1;
    localparam int REC_W  = 448;
    localparam int WORDS  = 14;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [NREC*REC_W-1:0]   records;
    logic                    rd_qual, fuse_en;
    logic                    we, re;
    logic [1:0]              addr;
    logic [31:0]             wdata;
    logic [31:0]             rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    state_readout_window #(.NUM_HW(NUM_HW)) u_state_readout_window (
        .clk_i(clk), .rst_i(rst), .records_i(records),
        .rd_qual_i(rd_qual), .fuse_en_i(fuse_en),
        .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    function automatic logic [31:0] expw(int r, int k);
        return {8'(r*17 + 3), 8'(k*11 + 1), 16'(r*1000 + k*7 + 16'h1234)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        re = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREC; r++)
            for (int k = 0; k < WORDS; k++)
                records[r*REC_W + k*32 +: 32] = expw(r, k);
        rst = 1'b1; rd_qual = 1'b1; fuse_en = 1'b1;
        we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        rd(2'd0, got); check("R1 sel", got, 32'd0);
        rd(2'd1, got); check("R1 word0", got, expw(0, 0));

        // R2 R3 R4 R6: sweep every selection
        for (int s = 0; s < 16; s++) begin
            wr(2'd0, 32'hFFFF_FFF0 | 32'(s));
            rd(2'd0, got); check("R2 readback", got, 32'(s));
            for (int k = 0; k < WORDS; k++) begin
                rd(2'd1, got);
                check(s < NREC ? "R3 word" : "R6 reserved", got, s < NREC ? expw(s, k) : 32'd0);
            end
            rd(2'd1, got);
            check(s < NREC ? "R4 wrap" : "R6 reserved wrap", got, s < NREC ? expw(s, 0) : 32'd0);
        end

        // R5: rewrite of the same selection mid-record
        wr(2'd0, 32'd1);
        for (int k = 0; k < 5; k++) rd(2'd1, got);
        wr(2'd0, 32'd1);
        rd(2'd1, got); check("R5 reselect", got, expw(1, 0));

        // R7: either enable low gives zero and holds pointer
        rd_qual = 1'b0;
        rd(2'd1, got); check("R7 qual low", got, 32'd0);
        rd(2'd1, got); check("R7 qual low", got, 32'd0);
        rd_qual = 1'b1; fuse_en = 1'b0;
        rd(2'd1, got); check("R7 fuse low", got, 32'd0);
        fuse_en = 1'b1;
        rd(2'd1, got); check("R7 resume", got, expw(1, 1));

        // R8: other reads do not advance
        rd(2'd0, got); check("R8 sel read", got, 32'd1);
        rd(2'd2, got); check("R8 rsv2", got, 32'd0);
        rd(2'd3, got); check("R8 rsv3", got, 32'd0);
        rd(2'd1, got); check("R8 no skip", got, expw(1, 2));

        // R9: idle output
        @(negedge clk); addr = 2'd1; #1 check("R9 idle val", rdata, 32'd0);
        addr = 2'd0; #1 check("R9 idle sel", rdata, 32'd0);

        // R1: reset again mid-record
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        rd(2'd1, got); check("R1 after reset", got, expw(0, 0));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule